// File: doc/BRIEF.md
# Segment Register Load Privilege Checker

This block decides, in one registered step, whether a selector may be placed in a segment register. The register is either the stack segment register or one of the four general data segment registers. Descriptor lookup happens elsewhere. The block receives the following inputs:

- the current privilege level;
- the three selector fields: descriptor index, table indicator and requested level;
- the limit of the descriptor table;
- the decoded descriptor bits: present, privilege level, code/data, writable and readable.

It returns a one-cycle response: either allow or fault. A fault carries a cause code that names the single most important reason for the refusal.

Privilege levels run from 0 to 3, and a smaller number means more privilege. Stack loads follow strict rules. Data loads follow a relaxed privilege rule and accept a null selector. A separate strobe reports a memory access made through a null segment, and the block always answers that strobe with a fault.

Top module: `segld_priv_check`

## Requirements
- R1: The response is registered. `rsp_valid` goes high one clock after `req_valid` or `null_ref` is sampled high, and is low otherwise. Synchronous reset clears `rsp_valid`, `rsp_allow`, `rsp_fault` and `rsp_cause` to 0.
- R2: A selector is null when `sel_index` is 0 and `sel_ti` is 0, whatever `sel_rpl` holds. A null selector loaded into a data register (`req_stack`=0) is allowed with cause 0, whatever the descriptor inputs and levels are.
- R3: A null selector loaded into the stack register (`req_stack`=1) faults with cause 1 (NULL).
- R4: A non-null load faults with cause 2 (LIMIT) when `sel_index`*8+7 is greater than `tbl_limit`. A value equal to the limit passes this test.
- R5: A stack load needs `dsc_is_code`=0 and `dsc_writable`=1. Otherwise it faults with cause 3 (TYPE).
- R6: A data load needs either `dsc_is_code`=0, or `dsc_is_code`=1 with `dsc_readable`=1. Otherwise it faults with cause 3 (TYPE).
- R7: A stack load passes the privilege test only when `cur_pl`, `sel_rpl` and `dsc_dpl` are all equal. Otherwise it faults with cause 4 (PRIV).
- R8: A data load passes the privilege test only when `dsc_dpl` >= max(`cur_pl`, `sel_rpl`). Otherwise it faults with cause 4 (PRIV).
- R9: A load whose descriptor has `dsc_present`=0 faults with cause 5 (NOTPRES).
- R10: When several causes apply, only the highest-priority cause is reported. The order, from highest to lowest, is NULL, LIMIT, TYPE, PRIV, NOTPRES.
- R11: `null_ref` high produces a fault with cause 6 (NULLREF) on the next cycle. It takes precedence over a load request sampled in the same cycle.
- R12: When `rsp_valid` is high, exactly one of `rsp_allow` and `rsp_fault` is high. `rsp_allow` implies cause 0. Both are low while `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe |
| req_stack | input | 1 | 1: target is the stack register, 0: a data register |
| null_ref | input | 1 | Memory access through a null segment |
| cur_pl | input | 2 | Current privilege level |
| sel_index | input | IDX_W | Selector descriptor index |
| sel_ti | input | 1 | Selector table indicator |
| sel_rpl | input | 2 | Selector requested level |
| tbl_limit | input | LIM_W | Descriptor table limit in bytes |
| dsc_present | input | 1 | Descriptor present bit |
| dsc_dpl | input | 2 | Descriptor privilege level |
| dsc_is_code | input | 1 | Descriptor is a code segment |
| dsc_writable | input | 1 | Data segment writable |
| dsc_readable | input | 1 | Code segment readable |
| rsp_valid | output | 1 | Response valid |
| rsp_allow | output | 1 | Load allowed |
| rsp_fault | output | 1 | Load or access faulted |
| rsp_cause | output | 3 | Fault cause code (0 when allowed) |

## Verification
Every result is due exactly one clock after its stimulus, because a single output register sits behind purely combinational decisions. The bench drives inputs on the falling edge, lets one rising edge pass, and samples all four outputs on the following falling edge. The expected value comes from an arithmetic model of the rules. The bench sweeps all 64 level triples for both targets, every type bit pattern, the limit boundary, null selectors with garbage descriptors and stacked fault combinations. Idle cycles are sampled in the same way to confirm that no response appears.

// File: rtl/segld_pkg.sv
package segld_pkg;

    localparam int PL_W    = 2;
    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_NULL    = 3'd1,
        CAUSE_LIMIT   = 3'd2,
        CAUSE_TYPE    = 3'd3,
        CAUSE_PRIV    = 3'd4,
        CAUSE_NOTPRES = 3'd5,
        CAUSE_NULLREF = 3'd6
    } cause_e;

    typedef struct packed {
        logic            present;
        logic [PL_W-1:0] dpl;
        logic            is_code;
        logic            writable;
        logic            readable;
    } dsc_t;

    typedef struct packed {
        logic            is_null;
        logic            lim_ok;
        logic            type_ok;
        logic            priv_ok;
        logic            present;
    } verdict_t;

    typedef struct packed {
        logic               valid;
        logic               allow;
        logic               fault;
        logic [CAUSE_W-1:0] cause;
    } rsp_t;

    function automatic logic [PL_W-1:0] pl_max(input logic [PL_W-1:0] a,
                                               input logic [PL_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/segld_sel_decode.sv
module segld_sel_decode #(
    parameter int IDX_W = 13,
    parameter int LIM_W = 16
) (
    input  logic [IDX_W-1:0] sel_index,
    input  logic             sel_ti,
    input  logic [LIM_W-1:0] tbl_limit,
    output logic             is_null,
    output logic             lim_ok
);
    localparam int END_W = IDX_W + 3;
    localparam int CMP_W = (END_W > LIM_W) ? END_W : LIM_W;

    logic [END_W-1:0] last_byte;
    logic [CMP_W-1:0] last_ext;
    logic [CMP_W-1:0] lim_ext;

    always_comb begin
        last_byte = {sel_index, 3'b111};
        last_ext  = CMP_W'(last_byte);
        lim_ext   = CMP_W'(tbl_limit);
        is_null   = (sel_index == '0) && !sel_ti;
        lim_ok    = (last_ext <= lim_ext);
    end
endmodule

// File: rtl/segld_rule_eval.sv
module segld_rule_eval
    import segld_pkg::*;
#(
    parameter bit STACK_RULES = 1'b0
) (
    input  logic [PL_W-1:0] cur_pl,
    input  logic [PL_W-1:0] sel_rpl,
    input  dsc_t            dsc,
    output logic            type_ok,
    output logic            priv_ok
);
    generate
        if (STACK_RULES) begin : g_stack
            always_comb begin
                type_ok = !dsc.is_code && dsc.writable;
                priv_ok = (cur_pl == sel_rpl) && (sel_rpl == dsc.dpl);
            end
        end else begin : g_data
            always_comb begin
                type_ok = !dsc.is_code || dsc.readable;
                priv_ok = (dsc.dpl >= pl_max(cur_pl, sel_rpl));
            end
        end
    endgenerate
endmodule

// File: rtl/segld_prio.sv
module segld_prio
    import segld_pkg::*;
(
    input  logic     is_stack,
    input  verdict_t vd,
    output cause_e   cause
);
    always_comb begin
        if (vd.is_null)
            cause = is_stack ? CAUSE_NULL : CAUSE_NONE;
        else if (!vd.lim_ok)
            cause = CAUSE_LIMIT;
        else if (!vd.type_ok)
            cause = CAUSE_TYPE;
        else if (!vd.priv_ok)
            cause = CAUSE_PRIV;
        else if (!vd.present)
            cause = CAUSE_NOTPRES;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/segld_priv_check.sv
module segld_priv_check
    import segld_pkg::*;
#(
    parameter int IDX_W = 13,
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_stack,
    input  logic             null_ref,
    input  logic [1:0]       cur_pl,
    input  logic [IDX_W-1:0] sel_index,
    input  logic             sel_ti,
    input  logic [1:0]       sel_rpl,
    input  logic [LIM_W-1:0] tbl_limit,
    input  logic             dsc_present,
    input  logic [1:0]       dsc_dpl,
    input  logic             dsc_is_code,
    input  logic             dsc_writable,
    input  logic             dsc_readable,
    output logic             rsp_valid,
    output logic             rsp_allow,
    output logic             rsp_fault,
    output logic [2:0]       rsp_cause
);
    localparam int N_KIND = 2;

    dsc_t     dsc;
    logic     is_null;
    logic     lim_ok;
    logic     type_ok_k [N_KIND];
    logic     priv_ok_k [N_KIND];
    verdict_t vd;
    cause_e   load_cause;
    rsp_t     rsp_d;
    rsp_t     rsp_q;

    always_comb begin
        dsc.present  = dsc_present;
        dsc.dpl      = dsc_dpl;
        dsc.is_code  = dsc_is_code;
        dsc.writable = dsc_writable;
        dsc.readable = dsc_readable;
    end

    segld_sel_decode #(.IDX_W(IDX_W), .LIM_W(LIM_W)) sel_dec_i (
        .sel_index (sel_index),
        .sel_ti    (sel_ti),
        .tbl_limit (tbl_limit),
        .is_null   (is_null),
        .lim_ok    (lim_ok)
    );

    // kind 0: data registers, kind 1: stack register
    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
        segld_rule_eval #(.STACK_RULES(k == 1)) rule_i (
            .cur_pl  (cur_pl),
            .sel_rpl (sel_rpl),
            .dsc     (dsc),
            .type_ok (type_ok_k[k]),
            .priv_ok (priv_ok_k[k])
        );
    end

    always_comb begin
        vd.is_null = is_null;
        vd.lim_ok  = lim_ok;
        vd.type_ok = type_ok_k[req_stack];
        vd.priv_ok = priv_ok_k[req_stack];
        vd.present = dsc.present;
    end

    segld_prio prio_i (
        .is_stack (req_stack),
        .vd       (vd),
        .cause    (load_cause)
    );

    always_comb begin
        rsp_d = '0;
        if (null_ref) begin
            rsp_d.valid = 1'b1;
            rsp_d.fault = 1'b1;
            rsp_d.cause = CAUSE_NULLREF;
        end else if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.allow = (load_cause == CAUSE_NONE);
            rsp_d.fault = (load_cause != CAUSE_NONE);
            rsp_d.cause = load_cause;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_allow = rsp_q.allow;
    assign rsp_fault = rsp_q.fault;
    assign rsp_cause = rsp_q.cause;
endmodule

// File: rtl/segld_priv_check_sva.sv
module segld_priv_check_sva #(
    parameter int IDX_W = 13,
    parameter int LIM_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_stack,
    input logic             null_ref,
    input logic [1:0]       cur_pl,
    input logic [IDX_W-1:0] sel_index,
    input logic             sel_ti,
    input logic [1:0]       sel_rpl,
    input logic [1:0]       dsc_dpl,
    input logic             rsp_valid,
    input logic             rsp_allow,
    input logic             rsp_fault,
    input logic [2:0]       rsp_cause
);
    p_resp_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid || null_ref) |=> rsp_valid);

    p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
        !(req_valid || null_ref) |=> !rsp_valid);

    p_null_data_ok_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !null_ref && !req_stack && sel_index == '0 && !sel_ti)
        |=> (rsp_allow && rsp_cause == 3'd0));

    p_null_stack_bad_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !null_ref && req_stack && sel_index == '0 && !sel_ti)
        |=> (rsp_fault && rsp_cause == 3'd1));

    p_stack_eq_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !null_ref && req_stack &&
         (cur_pl != sel_rpl || sel_rpl != dsc_dpl)) |=> !rsp_allow);

    p_data_max_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !null_ref && !req_stack && (sel_index != '0 || sel_ti) &&
         (dsc_dpl < cur_pl || dsc_dpl < sel_rpl)) |=> !rsp_allow);

    p_nullref_r11: assert property (@(posedge clk) disable iff (rst)
        null_ref |=> (rsp_fault && rsp_cause == 3'd6));

    p_one_outcome_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_allow != rsp_fault));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_allow && !rsp_fault));

    p_allow_clean_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_allow |-> (rsp_cause == 3'd0));
endmodule

bind segld_priv_check segld_priv_check_sva #(.IDX_W(IDX_W), .LIM_W(LIM_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_stack (req_stack),
    .null_ref  (null_ref),
    .cur_pl    (cur_pl),
    .sel_index (sel_index),
    .sel_ti    (sel_ti),
    .sel_rpl   (sel_rpl),
    .dsc_dpl   (dsc_dpl),
    .rsp_valid (rsp_valid),
    .rsp_allow (rsp_allow),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause)
);

// File: tb/segld_priv_check_tb.sv
module segld_priv_check_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 13;
    localparam int LIM_W = 16;
    localparam int WD_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_stack = 0, null_ref = 0;
    logic [1:0] cur_pl = 0, sel_rpl = 0, dsc_dpl = 0;
    logic [IDX_W-1:0] sel_index = 0;
    logic sel_ti = 0;
    logic [LIM_W-1:0] tbl_limit = 0;
    logic dsc_present = 0, dsc_is_code = 0, dsc_writable = 0, dsc_readable = 0;
    logic rsp_valid, rsp_allow, rsp_fault;
    logic [2:0] rsp_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    segld_priv_check #(.IDX_W(IDX_W), .LIM_W(LIM_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_stack(req_stack),
        .null_ref(null_ref), .cur_pl(cur_pl), .sel_index(sel_index),
        .sel_ti(sel_ti), .sel_rpl(sel_rpl), .tbl_limit(tbl_limit),
        .dsc_present(dsc_present), .dsc_dpl(dsc_dpl), .dsc_is_code(dsc_is_code),
        .dsc_writable(dsc_writable), .dsc_readable(dsc_readable),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause)
    );

    function automatic int ref_cause(bit stk, bit nref, int cpl, int idx, bit ti,
                                     int rpl, int lim, bit pres, int dpl,
                                     bit code, bit wr, bit rd);
        int mx;
        if (nref) return 6;
        if (idx == 0 && !ti) return stk ? 1 : 0;
        if (idx * 8 + 7 > lim) return 2;
        if (stk ? (code || !wr) : (code && !rd)) return 3;
        mx = (cpl > rpl) ? cpl : rpl;
        if (stk ? !(cpl == rpl && rpl == dpl) : (dpl < mx)) return 4;
        if (!pres) return 5;
        return 0;
    endfunction

    task automatic compare(string tag, bit ev, bit ea, bit ef, int ec);
        n_chk++;
        if (rsp_valid !== ev || rsp_allow !== ea || rsp_fault !== ef || int'(rsp_cause) != ec) begin
            n_bad++;
            $display("FAIL %s: got v=%0b a=%0b f=%0b c=%0d, want v=%0b a=%0b f=%0b c=%0d",
                     tag, rsp_valid, rsp_allow, rsp_fault, rsp_cause, ev, ea, ef, ec);
        end
    endtask

    // drive on falling edge, one rising edge passes, sample on next falling edge
    task automatic load(string tag, bit stk, bit nref, int cpl, int idx, bit ti,
                        int rpl, int lim, bit pres, int dpl, bit code, bit wr, bit rd);
        int c;
        req_valid = 1; req_stack = stk; null_ref = nref;
        cur_pl = 2'(cpl); sel_index = IDX_W'(idx); sel_ti = ti; sel_rpl = 2'(rpl);
        tbl_limit = LIM_W'(lim); dsc_present = pres; dsc_dpl = 2'(dpl);
        dsc_is_code = code; dsc_writable = wr; dsc_readable = rd;
        @(posedge clk); @(negedge clk);
        c = ref_cause(stk, nref, cpl, idx, ti, rpl, lim, pres, dpl, code, wr, rd);
        compare(tag, 1'b1, c == 0, c != 0, c);
        req_valid = 0; null_ref = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset", 0, 0, 0, 0);
        rst = 0;
        @(negedge clk);
        compare("R1 idle", 0, 0, 0, 0);

        // R7 / R8: full level sweep, both targets, otherwise good descriptor
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    for (int d = 0; d < 4; d++)
                        load(s ? "R7 stack levels" : "R8 data levels",
                             bit'(s), 0, c, 5, 0, r, 16'hFFFF, 1, d, 0, 1, 0);

        // R5 / R6: type bit patterns
        for (int s = 0; s < 2; s++)
            for (int t = 0; t < 8; t++)
                load(s ? "R5 stack type" : "R6 data type", bit'(s), 0, 1, 7, 1, 1,
                     16'hFFFF, 1, 1, bit'(t >> 2), bit'(t >> 1), bit'(t));

        // R4: limit boundary
        load("R4 end equals limit", 0, 0, 0, 2, 0, 0, 23, 1, 3, 0, 1, 0);
        load("R4 end past limit", 0, 0, 0, 3, 0, 0, 23, 1, 3, 0, 1, 0);
        load("R4 stack end equals", 1, 0, 2, 3, 1, 2, 31, 1, 2, 0, 1, 0);
        load("R4 stack past limit", 1, 0, 2, 4, 1, 2, 31, 1, 2, 0, 1, 0);
        load("R4 ti only selector", 0, 0, 0, 0, 1, 0, 6, 1, 3, 0, 1, 0);

        // R9: not present
        load("R9 data not present", 0, 0, 1, 9, 0, 1, 16'hFFFF, 0, 2, 0, 0, 0);
        load("R9 stack not present", 1, 0, 0, 9, 0, 0, 16'hFFFF, 0, 0, 0, 1, 0);

        // R2 / R3: null selectors with junk descriptors
        for (int r = 0; r < 4; r++) begin
            load("R2 null data", 0, 0, 3, 0, 0, r, 0, 0, 0, 1, 0, 0);
            load("R3 null stack", 1, 0, 0, 0, 0, r, 16'hFFFF, 1, 0, 0, 1, 0);
        end

        // R10: stacked causes
        load("R10 limit over rest", 1, 0, 3, 50, 0, 0, 15, 0, 1, 1, 0, 0);
        load("R10 type over priv", 1, 0, 3, 1, 0, 0, 15, 0, 1, 1, 0, 0);
        load("R10 priv over notpres", 0, 0, 3, 1, 0, 0, 15, 0, 1, 0, 0, 0);
        load("R10 null over all", 1, 0, 3, 0, 0, 2, 0, 0, 1, 1, 0, 0);

        // R11: null reference, with and without a load request
        load("R11 null ref with load", 0, 1, 0, 1, 0, 0, 16'hFFFF, 1, 3, 0, 1, 0);
        req_valid = 0; null_ref = 1;
        @(posedge clk); @(negedge clk);
        null_ref = 0;
        compare("R11 null ref alone", 1, 0, 1, 6);

        // R1 / R12: quiet after traffic stops
        @(posedge clk); @(negedge clk);
        compare("R12 quiet after traffic", 0, 0, 0, 0);

        // R1: reset mid-stream clears a pending response
        req_valid = 1; req_stack = 0; sel_index = 1; tbl_limit = 16'hFFFF;
        dsc_present = 1; dsc_dpl = 3;
        rst = 1;
        @(posedge clk); @(negedge clk);
        compare("R1 reset overrides", 0, 0, 0, 0);
        rst = 0; req_valid = 0;

        done = 1;
        summary();
    end
endmodule